// File: doc/BRIEF.md
# Outbound Address Window Enable Decoder

This block decides, for each CPU-side memory address presented with a valid strobe, whether the address lands in an outbound window that is switched on and so should be passed to the downstream bus. The top of the address space, from 0xF0000000 upward, is split into 32 chunks of 8 MiB. Each chunk has its own enable bit in a 32-bit enable register. A two-bit mode field in a control register gates every window at once.

The lowest chunk is held by firmware and the highest by the bridge's own register space. Neither of them forwards, whatever its enable bit holds. Windows map one to one, so the block translates no address. It reports a registered forward flag and the chunk index, one cycle after the strobe. Both registers are written through one write port and are always visible on read-back outputs.

A write to either register takes effect on the decision made in the same cycle. Software can therefore open or close windows without a dead cycle in which stale settings apply.

Top module: `outwin_decoder`

## Requirements
- R1: After reset, fwd_vld and fwd_hit are 0, fwd_idx is 0, and both read-back outputs are 0.
- R2: fwd_vld is 1 in the cycle after a cycle with addr_vld high and 0 in the cycle after a cycle with addr_vld low. fwd_hit is 1 only when fwd_vld is 1.
- R3: An address below 0xF0000000 never forwards, and its reported fwd_idx is 0.
- R4: For an address at or above 0xF0000000, fwd_idx equals (address - 0xF0000000) / 8 MiB, which is address bits [27:23].
- R5: Forwarding happens only when control bits [8:7] equal binary 01. The codes 00, 10 and 11 block every window.
- R6: Chunks 0 and 31 never forward, even with their enable bits (bit 0 and bit 31) set and mode 01.
- R7: With mode 01, an address in chunk i, where 1 <= i <= 30, forwards exactly when enable bit i is set.
- R8: en_rd returns the enable register exactly as written, bits 0 and 31 included. ctl_rd returns the full control word as written.
- R9: A register write in the same cycle as an address strobe is applied to that strobe's decision.
- R10: cfg_wr with cfg_sel=0 writes the enable register, and with cfg_sel=1 writes the control register. The other register is left unchanged. With cfg_wr low, neither register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 enable, 1 control |
| cfg_wdata | input | 32 | Write data |
| addr_vld | input | 1 | Address strobe |
| addr_i | input | 32 | CPU-side address |
| en_rd | output | 32 | Enable register read-back |
| ctl_rd | output | 32 | Control register read-back |
| fwd_vld | output | 1 | Decision valid, one cycle after addr_vld |
| fwd_hit | output | 1 | Address forwards |
| fwd_idx | output | 5 | Chunk index of the address |

## Verification
The hardest cases to reach from the ports are the two reserved chunks with their enable bits set while the mode is on, and a write that lands in the very cycle of a strobe. A walking-one enable pattern is swept against every chunk under each of the four mode codes, and all enables are also set at once. This places bits 0 and 31 in front of their own chunks with the mode both open and shut. Separate probes drive cfg_wr together with addr_vld, opening and closing a window and flipping the mode in that cycle, so a decision that used the old settings would be caught.

// File: rtl/outwin_decoder.sv
module outwin_decoder #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int N_CHUNK  = 32,
  parameter int CHUNK_LG = 23,
  parameter logic [ADDR_W-1:0] BASE = 32'hF000_0000,
  parameter int MODE_LO  = 7,
  parameter logic [1:0] MODE_ON = 2'b01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic                   cfg_sel,
  input  logic [DATA_W-1:0]      cfg_wdata,
  input  logic                   addr_vld,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic [N_CHUNK-1:0]     en_rd,
  output logic [DATA_W-1:0]      ctl_rd,
  output logic                   fwd_vld,
  output logic                   fwd_hit,
  output logic [$clog2(N_CHUNK)-1:0] fwd_idx
);
  localparam int IDX_W = $clog2(N_CHUNK);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(N_CHUNK) << CHUNK_LG;
  localparam logic [N_CHUNK-1:0] LIVE_MASK = {1'b0, {(N_CHUNK-2){1'b1}}, 1'b0};

  logic [N_CHUNK-1:0] en_q, en_nxt, live;
  logic [DATA_W-1:0]  ctl_q, ctl_nxt;
  logic [ADDR_W:0]    off;
  logic [IDX_W-1:0]   idx;
  logic               in_rng, mode_on;

  assign en_nxt  = (cfg_wr && !cfg_sel) ? cfg_wdata[N_CHUNK-1:0] : en_q;
  assign ctl_nxt = (cfg_wr &&  cfg_sel) ? cfg_wdata : ctl_q;

  assign off     = {1'b0, addr_i} - {1'b0, BASE};
  assign in_rng  = (addr_i >= BASE) && (off < SPAN);
  assign idx     = off[CHUNK_LG +: IDX_W];
  assign live    = en_nxt & LIVE_MASK;
  assign mode_on = ctl_nxt[MODE_LO +: 2] == MODE_ON;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      ctl_q   <= '0;
      fwd_vld <= 1'b0;
      fwd_hit <= 1'b0;
      fwd_idx <= '0;
    end else begin
      en_q    <= en_nxt;
      ctl_q   <= ctl_nxt;
      fwd_vld <= addr_vld;
      fwd_hit <= addr_vld && in_rng && mode_on && live[idx];
      fwd_idx <= (addr_vld && in_rng) ? idx : '0;
    end
  end

  assign en_rd  = en_q;
  assign ctl_rd = ctl_q;
endmodule

module outwin_decoder_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int N_CHUNK  = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hF000_0000,
  parameter int MODE_LO  = 7,
  parameter logic [1:0] MODE_ON = 2'b01
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_wr,
  input logic                   addr_vld,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [N_CHUNK-1:0]     en_rd,
  input logic [DATA_W-1:0]      ctl_rd,
  input logic                   fwd_vld,
  input logic                   fwd_hit,
  input logic [$clog2(N_CHUNK)-1:0] fwd_idx
);
  assert_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> fwd_vld);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> !fwd_vld && !fwd_hit);
  assert_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && addr_i < BASE) |=> !fwd_hit && fwd_idx == '0);
  assert_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> ctl_rd[MODE_LO +: 2] == MODE_ON);
  assert_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (fwd_idx != '0) && (fwd_idx != N_CHUNK-1));
  assert_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> en_rd[fwd_idx]);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(en_rd) && $stable(ctl_rd));
endmodule

bind outwin_decoder outwin_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CHUNK(N_CHUNK),
  .BASE(BASE), .MODE_LO(MODE_LO), .MODE_ON(MODE_ON)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .addr_vld(addr_vld),
  .addr_i(addr_i), .en_rd(en_rd), .ctl_rd(ctl_rd), .fwd_vld(fwd_vld),
  .fwd_hit(fwd_hit), .fwd_idx(fwd_idx)
);

// File: tb/tb_outwin_decoder.sv
`timescale 1ns/1ps
module tb_outwin_decoder;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic addr_vld = 0;
  logic [31:0] addr_i = 0;
  logic [31:0] en_rd, ctl_rd;
  logic fwd_vld, fwd_hit;
  logic [4:0] fwd_idx;

  int checks = 0, fails = 0;
  logic [31:0] en_m = 0, ctl_m = 0;

  always #5 clk = ~clk;

  outwin_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .addr_vld(addr_vld), .addr_i(addr_i),
    .en_rd(en_rd), .ctl_rd(ctl_rd), .fwd_vld(fwd_vld),
    .fwd_hit(fwd_hit), .fwd_idx(fwd_idx)
  );

  function automatic logic exp_hit(input logic [31:0] a);
    int i;
    if (a < 32'hF000_0000) return 1'b0;
    i = int'(a[27:23]);
    return (ctl_m[8:7] == 2'b01) && (i >= 1) && (i <= 30) && en_m[i];
  endfunction

  function automatic logic [4:0] exp_idx(input logic [31:0] a);
    return (a >= 32'hF000_0000) ? 5'((a - 32'hF000_0000) >> 23) : 5'd0;
  endfunction

  task automatic check_out(input logic [31:0] a, input string tag);
    logic eh; logic [4:0] ei;
    eh = exp_hit(a); ei = exp_idx(a);
    checks++;
    if (fwd_vld !== 1'b1 || fwd_hit !== eh || fwd_idx !== ei) begin
      fails++;
      $display("FAIL %s addr=%h vld=%b/1 hit=%b/%b idx=%0d/%0d",
               tag, a, fwd_vld, fwd_hit, eh, fwd_idx, ei);
    end
  endtask

  task automatic probe(input logic [31:0] a, input string tag);
    @(negedge clk); addr_vld = 1; addr_i = a;
    @(negedge clk); addr_vld = 0;
    check_out(a, tag);
  endtask

  task automatic check_idle();
    checks++;
    if (fwd_vld !== 1'b0 || fwd_hit !== 1'b0) begin
      fails++;
      $display("FAIL R2 idle vld=%b/0 hit=%b/0", fwd_vld, fwd_hit);
    end
  endtask

  task automatic check_regs(input string tag);
    checks++;
    if (en_rd !== en_m || ctl_rd !== ctl_m) begin
      fails++;
      $display("FAIL %s en=%h/%h ctl=%h/%h", tag, en_rd, en_m, ctl_rd, ctl_m);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    if (sel) ctl_m = d; else en_m = d;
    @(negedge clk); cfg_wr = 0;
    check_regs("R10");
  endtask

  task automatic probe_wr(input logic sel, input logic [31:0] d, input logic [31:0] a);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    addr_vld = 1; addr_i = a;
    if (sel) ctl_m = d; else en_m = d;
    @(negedge clk); cfg_wr = 0; addr_vld = 0;
    check_out(a, "R9");
  endtask

  function automatic logic [31:0] chunk_addr(input int i, input int salt);
    return 32'hF000_0000 + (32'(i) << 23) + ((32'(i) * 32'h1_2345 + 32'(salt) * 32'h3_0F1D) & 32'h7F_FFFF);
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (fwd_vld !== 0 || fwd_hit !== 0 || fwd_idx !== 0 || en_rd !== 0 || ctl_rd !== 0) begin
      fails++;
      $display("FAIL R1 vld=%b hit=%b idx=%0d en=%h ctl=%h all/0",
               fwd_vld, fwd_hit, fwd_idx, en_rd, ctl_rd);
    end
    rst_n = 1;
    @(negedge clk); check_idle();

    // R8: bits 0 and 31 read back as written
    wr(1'b0, 32'hFFFF_FFFF);
    wr(1'b1, 32'hDEAD_BEEF);
    check_regs("R8");
    wr(1'b0, 32'h8000_0001);
    check_regs("R8");

    // R3: low addresses, mode on and all enabled
    wr(1'b1, 32'h0000_0080);
    wr(1'b0, 32'hFFFF_FFFF);
    probe(32'h0000_0000, "R3");
    probe(32'hEFFF_FFFF, "R3");
    probe(32'h8000_0000, "R3");
    probe(32'h7654_3210, "R3");
    @(negedge clk); check_idle();

    // R6, R4: all enables set, sweep chunks
    for (int i = 0; i < 32; i++) probe(chunk_addr(i, 0), "R6");
    probe(32'hF000_0000, "R4");
    probe(32'hF07F_FFFF, "R4");
    probe(32'hF080_0000, "R4");
    probe(32'hFF7F_FFFF, "R4");
    probe(32'hFF80_0000, "R6");
    probe(32'hFFFF_FFFF, "R6");

    // R5, R7: walking one under every mode code
    for (int m = 0; m < 4; m++) begin
      wr(1'b1, (32'hA5A5_5A00 & ~32'h180) | (32'(m) << 7) | 32'h3F);
      for (int j = 0; j < 32; j++) begin
        wr(1'b0, 32'h1 << j);
        for (int i = 0; i < 32; i++)
          probe(chunk_addr(i, j), (m == 1) ? "R7" : "R5");
      end
    end

    // R7: alternating pattern, mode on
    wr(1'b1, 32'h0000_0080);
    wr(1'b0, 32'h5555_AAAA);
    for (int i = 0; i < 32; i++) probe(chunk_addr(i, 7), "R7");

    // R10: control write leaves enable untouched and vice versa
    wr(1'b1, 32'h0000_0180);
    probe(chunk_addr(2, 1), "R5");
    wr(1'b0, 32'h0000_0004);
    check_regs("R10");

    // R9: same-cycle write and strobe
    wr(1'b1, 32'h0000_0080);
    wr(1'b0, 32'h0000_0000);
    probe_wr(1'b0, 32'h0000_0008, chunk_addr(3, 2));
    probe_wr(1'b0, 32'h0000_0000, chunk_addr(3, 3));
    wr(1'b0, 32'h0000_0010);
    probe_wr(1'b1, 32'h0000_0100, chunk_addr(4, 4));
    probe_wr(1'b1, 32'h0000_0080, chunk_addr(4, 5));
    @(negedge clk); check_idle();
    check_regs("R10");

    summary();
  end
endmodule